// File: doc/BRIEF.md
# Time-Addressed Lookup Sequencer

The block plays back a stored waveform. A pattern memory holds one word per time step. An address counter walks that memory from word 0 up to a programmed last word, then returns to word 0 and repeats without end. The memory address is therefore elapsed time. The low fifteen bits of each word appear on fifteen parallel output lines. The top bit marks a point in the cycle and produces a one-clock strobe. Every output comes from a flop on the same clock edge, so all lines change together and do not glitch.

A time step lasts `BASE_DIV * 2^k` clocks. `BASE_DIV` turns the system clock into a base tick; it is the number of clocks per microsecond in a real build. The value k ranges from 0 to 7 and is selected at run time. While the sequencer is stopped, a host loads the memory through a simple write port and sets the step size and the last address. Once `run_i` goes high, the block runs on its own with no further host traffic.

Top module: `lut_seq`

## Requirements
- R1: While `run_i` is low, `out_o` and `mark_o` are 0 from the next clock edge on, and the sequence position returns to word 0. After reset, both outputs are 0.
- R2: Take the first edge at which `run_i` is sampled high as edge 1. After edge m (m >= 2), `out_o` equals bits [14:0] of word `((m-2)/P) mod (L+1)`. Here P = `BASE_DIV*2^k` clocks and L is the latched last address. After edge 1, `out_o` is still 0. Each word is therefore held for exactly P clocks.
- R3: The word index counts 0, 1, ..., L and then wraps to 0. This repeats for as long as `run_i` stays high. It holds for L = 0 and for L at the top of the address range.
- R4: `div_sel_i` = k, with k from 0 to 7, selects a step of `BASE_DIV * 2^k` clocks.
- R5: `mark_o` is high for the one clock after edge m when `(m-2) mod P == 0` and bit 15 of the word then shown is 1. Otherwise it is 0.
- R6: A write (`wr_en_i` high at a clock edge) stores `wr_data_i` at `wr_addr_i` only if `run_i` is low at that edge. Writes made while running leave the memory unchanged.
- R7: `div_sel_i` and `last_i` are latched at every edge at which `run_i` is low. Changes to them while running have no effect until the next stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 runs the sequence, 0 stops it and rewinds to word 0 |
| div_sel_i | input | 3 | Step-size exponent k; the step is BASE_DIV*2^k clocks |
| last_i | input | ADDR_W | Last address of the cycle |
| wr_en_i | input | 1 | Memory write strobe, honoured only while stopped |
| wr_addr_i | input | ADDR_W | Memory write address |
| wr_data_i | input | DATA_W | Memory write word; bit DATA_W-1 is the marker |
| out_o | output | DATA_W-1 | Registered pattern outputs |
| mark_o | output | 1 | One-clock strobe when a marked word begins |

## Verification
The fault classes below show up at the ports within a known delay:

- **Step timer off by a clock.** A word's edge lands early or late. This shows within the first word, which is at most `BASE_DIV*128` clocks.
- **Wrong wrap point or missed return to zero.** Words appear out of order. This shows at the first cycle boundary, because every word carries a distinct pattern.
- **Latch or write gating that leaks while running.** A later run shows altered words or altered timing. This shows the first time word 0 or word 1 comes back.
- **Stuck marker pipeline.** The strobe appears on the wrong clock or lasts more than one clock. This shows at the next marked word.

// File: rtl/lut_seq_pkg.sv
`timescale 1ns/1ps
package lut_seq_pkg;
  localparam int DIV_SEL_W = 3;
  localparam int POW_W     = (1 << DIV_SEL_W) - 1;

  function automatic logic [POW_W-1:0] pow_last(input logic [DIV_SEL_W-1:0] k);
    return POW_W'((32'd1 << k) - 32'd1);
  endfunction
endpackage

// File: rtl/lut_seq_tick.sv
`timescale 1ns/1ps
module lut_seq_tick
  import lut_seq_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 tick_o
);
  localparam int BASE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic             base_hit;
  logic [POW_W-1:0] pow_cnt;
  logic [POW_W-1:0] pow_end;

  generate
    if (BASE_DIV > 1) begin : g_base
      logic [BASE_W-1:0] base_cnt;
      assign base_hit = (base_cnt == BASE_W'(BASE_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       base_cnt <= '0;
        else if (!run_i)   base_cnt <= '0;
        else if (base_hit) base_cnt <= '0;
        else               base_cnt <= base_cnt + 1'b1;
      end
    end else begin : g_nobase
      assign base_hit = 1'b1;
    end
  endgenerate

  assign pow_end = pow_last(div_sel_i);
  assign tick_o  = run_i & base_hit & (pow_cnt == pow_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pow_cnt <= '0;
    else if (!run_i)   pow_cnt <= '0;
    else if (base_hit) pow_cnt <= (pow_cnt == pow_end) ? '0 : pow_cnt + 1'b1;
  end
endmodule

// File: rtl/lut_seq_addr.sv
`timescale 1ns/1ps
module lut_seq_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              adv_o
);
  // adv_o flags that addr_o holds a word not yet presented
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      adv_o  <= 1'b1;
    end else if (!run_i) begin
      addr_o <= '0;
      adv_o  <= 1'b1;
    end else begin
      adv_o <= tick_i;
      if (tick_i) addr_o <= (addr_o == last_i) ? '0 : addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/lut_seq_mem.sv
`timescale 1ns/1ps
module lut_seq_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/lut_seq.sv
`timescale 1ns/1ps
module lut_seq
  import lut_seq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BASE_DIV = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [ADDR_W-1:0]    last_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-2:0]    out_o,
  output logic                 mark_o
);
  localparam int OUT_W = DATA_W - 1;

  logic [DIV_SEL_W-1:0] div_q;
  logic [ADDR_W-1:0]    last_q;
  logic                 tick;
  logic [ADDR_W-1:0]    addr;
  logic                 adv;
  logic [DATA_W-1:0]    rd_data;
  logic                 vld_q;
  logic                 fresh_q;

  // config is captured only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      last_q <= '0;
    end else if (!run_i) begin
      div_q  <= div_sel_i;
      last_q <= last_i;
    end
  end

  lut_seq_tick #(.BASE_DIV(BASE_DIV)) i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .div_sel_i (div_q),
    .tick_o    (tick)
  );

  lut_seq_addr #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .tick_i (tick),
    .last_i (last_q),
    .addr_o (addr),
    .adv_o  (adv)
  );

  lut_seq_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i & ~run_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (addr),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      fresh_q <= 1'b0;
      out_o   <= '0;
      mark_o  <= 1'b0;
    end else if (!run_i) begin
      vld_q   <= 1'b0;
      fresh_q <= 1'b0;
      out_o   <= '0;
      mark_o  <= 1'b0;
    end else begin
      vld_q   <= 1'b1;
      fresh_q <= adv;
      out_o   <= vld_q ? rd_data[OUT_W-1:0] : '0;
      mark_o  <= vld_q & fresh_q & rd_data[DATA_W-1];
    end
  end
endmodule

// File: rtl/lut_seq_chk.sv
`timescale 1ns/1ps
module lut_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 15,
  parameter int DSW    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic [OUT_W-1:0]  out_o,
  input logic              mark_o,
  input logic              tick,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] last_q,
  input logic [DSW-1:0]    div_q
);
  p_stop_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (out_o == '0 && !mark_o));

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick) |=> ($stable(addr) || addr == '0));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && addr == last_q) |=> (addr == '0));

  p_addr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (addr <= last_q));

  p_mark_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> $past(run_i));

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> ($stable(div_q) && $stable(last_q)));
endmodule

bind lut_seq lut_seq_chk #(.ADDR_W(ADDR_W), .OUT_W(DATA_W-1), .DSW(lut_seq_pkg::DIV_SEL_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run_i),
  .out_o  (out_o),
  .mark_o (mark_o),
  .tick   (tick),
  .addr   (addr),
  .last_q (last_q),
  .div_q  (div_q)
);

// File: tb/test_lut_seq.sv
`timescale 1ns/1ps
module test_lut_seq;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int BASE_DIV = 4;
  localparam int DEPTH    = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              run_i = 1'b0;
  logic [2:0]        div_sel_i = '0;
  logic [ADDR_W-1:0] last_i = '0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [DATA_W-2:0] out_o;
  logic              mark_o;

  int vectors = 0;
  int errors  = 0;
  logic [DATA_W-1:0] model [DEPTH];

  lut_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_DIV(BASE_DIV)) i_lut_seq (.*);

  always #2.5 clk_i = ~clk_i;

  // {k, last, cycles, disturb}
  typedef struct packed {
    logic [2:0]  k;
    logic [7:0]  last;
    logic [15:0] cycles;
    logic        disturb;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{3'd0, 8'd5,   16'd40,   1'b0},
    '{3'd1, 8'd255, 16'd2100, 1'b0},
    '{3'd2, 8'd0,   16'd100,  1'b0},
    '{3'd7, 8'd2,   16'd2200, 1'b0},
    '{3'd3, 8'd9,   16'd900,  1'b1}
  };

  function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
    logic [14:0] lo;
    lo = 15'((a * 1237 + 91 + salt * 311) & 16'h7fff);
    return {((a + salt) % 3 == 0), lo};
  endfunction

  task automatic check(input string tag, input logic [DATA_W-2:0] exp_out, input logic exp_mark);
    vectors++;
    if (out_o !== exp_out || mark_o !== exp_mark) begin
      errors++;
      $display("FAIL %s: out=%h mark=%b expected out=%h mark=%b", tag, out_o, mark_o, exp_out, exp_mark);
    end
  endtask

  task automatic load(input int salt);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = ADDR_W'(a); wr_data_i = pat(a, salt);
      model[a] = pat(a, salt);
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run_seq(input vec_t v);
    int p, w;
    string tag;
    p = BASE_DIV * (1 << v.k);
    tag = v.disturb ? "R6 R7 (run while disturbed)" : "R2 R3 R4 R5";
    @(negedge clk_i);
    div_sel_i = v.k; last_i = v.last;
    @(negedge clk_i);
    run_i = 1'b1;
    for (int m = 1; m <= int'(v.cycles); m++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (v.disturb && m == 50) begin
        div_sel_i = 3'd0; last_i = 8'd1;
        wr_en_i = 1'b1; wr_addr_i = 8'd1; wr_data_i = 16'hffff;
      end
      if (v.disturb && m == 60) begin
        wr_en_i = 1'b1; wr_addr_i = 8'd0; wr_data_i = 16'h0000;
      end
      if (v.disturb && (m == 51 || m == 61)) wr_en_i = 1'b0;
      if (m == 1) begin
        check("R1 R2 first edge", '0, 1'b0);
      end else begin
        w = ((m - 2) / p) % (int'(v.last) + 1);
        check(tag, model[w][DATA_W-2:0], ((m - 2) % p == 0) && model[w][DATA_W-1]);
      end
    end
    run_i = 1'b0;
    wr_en_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1 stop", '0, 1'b0);
  endtask

  initial begin
    #1;
    check("R1 reset", '0, 1'b0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 after reset", '0, 1'b0);
    load(0);
    check("R1 stopped during load", '0, 1'b0);
    for (int i = 0; i < 5; i++) run_seq(VECS[i]);
    // R6: writes while stopped take effect
    load(7);
    run_seq('{3'd0, 8'd7, 16'd30, 1'b0});
    run_seq('{3'd2, 8'd3, 16'd80, 1'b0});
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: out=%h mark=%b expected out=%h mark=%b", out_o, mark_o, 15'h0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule